// File: doc/BRIEF.md
# Memory-Controller Interrupt Aggregator

This block gathers the interrupt sources of an external memory controller and drives one interrupt line to the processor. There are two kinds of source:

- Two single-cycle event pulses from the NAND engine: a FIFO event and a terminal-count event.
- Edge events found on a parameterized set of asynchronous wait-pin inputs.

Each wait pin passes through a two-flop synchronizer. A small two-state machine then tracks the settled level of the pin.

- **States.** `WP_LOW` means the last settled level was 0. `WP_HIGH` means it was 1.
- **Transitions.** *rise* goes from `WP_LOW` to `WP_HIGH`. *fall* goes from `WP_HIGH` to `WP_LOW`. *hold* keeps the present state.
- **Event rule.** A *rise* reports an event only when the pin's polarity bit is 0. A *fall* reports an event only when that bit is 1.

Software reaches three word registers through a simple write-strobe and combinational-read port:

- **Address 0, status.** Sticky status bits, cleared by writing 1.
- **Address 1, enable.** The enable mask.
- **Address 2, polarity.** The per-pin edge-polarity bits.
- **Address 3.** Reads as zero.

The interrupt output is a registered OR of the status bits that are enabled.

Top module: `memctl_irq_agg`

## Requirements
- R1: Status bit 0 records the NAND FIFO event pulse and status bit 1 records the NAND terminal-count pulse; the status register is read at address 0.
- R2: Bits 2 to 7 of the status, enable and polarity registers, and every bit at or above 8+NUM_WAIT, always read as 0 and ignore writes; the polarity register also ignores writes to bits 0 and 1.
- R3: The edge event of wait pin n sets status bit 8+n; enable bit 8+n (enable register at address 1) gates it.
- R4: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R5: Polarity bit 8+n (polarity register at address 2) set to 0 makes pin n report only rising edges, and set to 1 only falling edges; the opposite edge is ignored.
- R6: The NAND status bits set on their pulses whatever the polarity register holds.
- R7: A set status bit whose enable bit is 0 does not drive the interrupt output.
- R8: `irq_out` equals, one clock after the fact, the OR over all bits of status AND enable.
- R9: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends set.
- R10: A wait-pin level change first sampled at clock edge k sets its status bit at edge k+2.
- R11: After reset all registers read 0 (rising-edge detection, every source disabled) and `irq_out` is 0.
- R12: A status bit sets on its event even while its enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nand_fifo_evt | input | 1 | NAND FIFO event pulse |
| nand_tc_evt | input | 1 | NAND terminal-count pulse |
| wait_pin | input | NUM_WAIT | Asynchronous wait-pin inputs |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
A wrong edge-machine state shows up as a spurious or missing status bit for that pin. This appears two edges after the pin settles, and the interrupt line follows one edge later. A corrupted status, enable or polarity bit can be read back at once through `reg_rdata`. It also shows on `irq_out` within one clock. The bench therefore compares `irq_out` against a behavioural model every clock and compares the addressed register every clock. It also probes the exact edge at which a pin change lands.

// File: rtl/memctl_irq_pkg.sv
package memctl_irq_pkg;

    localparam int NAND_SRC   = 2;
    localparam int WAIT_BASE  = 8;

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_ENABLE = 2'd1,
        ADDR_POLAR  = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        WP_LOW  = 1'b0,
        WP_HIGH = 1'b1
    } wp_state_e;

endpackage

// File: rtl/wait_sync.sv
module wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_async};
        end
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wait_edge_fsm.sv
module wait_edge_fsm
    import memctl_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic fall_sel,
    output logic edge_evt
);
    wp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WP_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        edge_evt = 1'b0;
        unique case (state_q)
            WP_LOW: begin
                if (level) begin
                    state_d  = WP_HIGH;
                    edge_evt = !fall_sel;
                end
            end
            WP_HIGH: begin
                if (!level) begin
                    state_d  = WP_LOW;
                    edge_evt = fall_sel;
                end
            end
        endcase
    end

    // R5: a reported edge always coincides with a state transition
    a_r5_evt_moves_state: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> (state_q != $past(state_q)));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import memctl_irq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_WAIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] polar,
    output logic              irq_out
);
    localparam logic [DATA_W-1:0] NAND_MASK  = DATA_W'((1 << NAND_SRC) - 1);
    localparam logic [DATA_W-1:0] WAIT_MASK  = DATA_W'((1 << NUM_WAIT) - 1) << WAIT_BASE;
    localparam logic [DATA_W-1:0] VALID_MASK = NAND_MASK | WAIT_MASK;

    reg_addr_e         addr_e;
    logic [DATA_W-1:0] status_q, enable_q, polar_q;
    logic [DATA_W-1:0] clr_vec;
    logic              irq_q;

    assign addr_e  = reg_addr_e'(addr);
    assign clr_vec = (wr_en && addr_e == ADDR_STATUS) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            polar_q  <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= ((status_q & ~clr_vec) | set_vec) & VALID_MASK;
            if (wr_en && addr_e == ADDR_ENABLE) begin
                enable_q <= wdata & VALID_MASK;
            end
            if (wr_en && addr_e == ADDR_POLAR) begin
                polar_q <= wdata & WAIT_MASK;
            end
            irq_q <= |(status_q & enable_q);
        end
    end

    always_comb begin
        unique case (addr_e)
            ADDR_STATUS: rdata = status_q;
            ADDR_ENABLE: rdata = enable_q;
            ADDR_POLAR:  rdata = polar_q;
            ADDR_SPARE:  rdata = '0;
        endcase
    end

    assign polar   = polar_q;
    assign irq_out = irq_q;

    // R9: an arriving event always lands, even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R4: bits written with 1 and not re-set in that cycle end cleared
    a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_e == ADDR_STATUS) |=>
        ((status_q & $past(wdata & ~set_vec & VALID_MASK)) == '0));

    // R7: no enabled pending source means no interrupt next cycle
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & enable_q) == '0) |=> !irq_out);

    // R2: reserved status bits never set
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & ~VALID_MASK) == '0));
endmodule

// File: rtl/memctl_irq_agg.sv
module memctl_irq_agg
    import memctl_irq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_WAIT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nand_fifo_evt,
    input  logic                nand_tc_evt,
    input  logic [NUM_WAIT-1:0] wait_pin,
    input  logic                reg_wr_en,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_out
);
    logic [NUM_WAIT-1:0] pin_lvl;
    logic [NUM_WAIT-1:0] pin_evt;
    logic [DATA_W-1:0]   polar;
    logic [DATA_W-1:0]   set_vec;

    for (genvar g = 0; g < NUM_WAIT; g++) begin : g_pin
        wait_sync #(.STAGES(2)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (wait_pin[g]),
            .pin_sync  (pin_lvl[g])
        );
        wait_edge_fsm u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (pin_lvl[g]),
            .fall_sel (polar[WAIT_BASE+g]),
            .edge_evt (pin_evt[g])
        );
    end

    always_comb begin
        set_vec    = '0;
        set_vec[0] = nand_fifo_evt;
        set_vec[1] = nand_tc_evt;
        for (int i = 0; i < NUM_WAIT; i++) begin
            set_vec[WAIT_BASE+i] = pin_evt[i];
        end
    end

    irq_regs #(.DATA_W(DATA_W), .NUM_WAIT(NUM_WAIT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .polar   (polar),
        .irq_out (irq_out)
    );
endmodule

// File: tb/memctl_irq_agg_bench.sv
module memctl_irq_agg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam logic [31:0] WMASK = 32'hF00;
    localparam logic [31:0] VMASK = 32'hF03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo = 1'b0, tc = 1'b0;
    logic [NW-1:0] pins = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    memctl_irq_agg #(.DATA_W(32), .NUM_WAIT(NW)) u_memctl_irq_agg (
        .clk(clk), .rst_n(rst_n), .nand_fifo_evt(fifo), .nand_tc_evt(tc),
        .wait_pin(pins), .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_out(irq_out));

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [31:0] m_status, m_enable, m_polar;
    logic        m_irq;
    logic [NW-1:0] h1, h2, h3;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_status = 0; m_enable = 0; m_polar = 0; m_irq = 0;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            logic nxt_irq;
            logic [31:0] setv, clr;
            nxt_irq = |(m_status & m_enable);
            setv = {30'd0, tc, fifo};
            for (int p = 0; p < NW; p++) begin
                if (m_polar[8+p]) begin
                    if (!h2[p] && h3[p]) setv[8+p] = 1'b1;
                end else begin
                    if (h2[p] && !h3[p]) setv[8+p] = 1'b1;
                end
            end
            clr = (wr && addr == 2'd0) ? wdata : 32'd0;
            m_status = ((m_status & ~clr) | setv) & VMASK;
            if (wr && addr == 2'd1) m_enable = wdata & VMASK;
            if (wr && addr == 2'd2) m_polar = wdata & WMASK;
            h3 = h2; h2 = h1; h1 = pins;
            m_irq = nxt_irq;
        end
    end

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_status;
            2'd1: return m_enable;
            2'd2: return m_polar;
            default: return 32'd0;
        endcase
    endfunction

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            checks++;
            if (irq_out !== m_irq) begin
                errors++;
                $display("FAIL R8 irq_out actual %0b expected %0b at %0t", irq_out, m_irq, $time);
            end
            checks++;
            if (rdata !== model_read(addr)) begin
                errors++;
                $display("FAIL R4 reg[%0d] actual %h expected %h at %0t", addr, rdata, model_read(addr), $time);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = 2'd0; wdata = '0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R11 reset state
        rd(2'd0, 32'h0, "R11 status");
        rd(2'd1, 32'h0, "R11 enable");
        rd(2'd2, 32'h0, "R11 polar");
        check("R11 irq", {31'd0, irq_out}, 32'h0);

        // R1 / R12: NAND events set status while disabled
        fifo = 1; cyc(1); fifo = 0; cyc(1);
        rd(2'd0, 32'h1, "R1 fifo bit0");
        tc = 1; cyc(1); tc = 0; cyc(2);
        rd(2'd0, 32'h3, "R12 set while disabled");
        check("R7 disabled no irq", {31'd0, irq_out}, 32'h0);

        // R2: reserved bits of enable
        wreg(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, VMASK, "R2 enable mask");
        cyc(1);
        check("R8 irq rises", {31'd0, irq_out}, 32'h1);

        // R4 write-1-to-clear
        wreg(2'd0, 32'h2);
        rd(2'd0, 32'h1, "R4 clear bit1");
        wreg(2'd0, 32'h0);
        rd(2'd0, 32'h1, "R4 write0 no effect");
        wreg(2'd0, 32'hFC);
        rd(2'd0, 32'h1, "R2 reserved status write");
        wreg(2'd0, 32'h1);
        rd(2'd0, 32'h0, "R4 clear bit0");
        cyc(2);
        check("R8 irq falls", {31'd0, irq_out}, 32'h0);

        // R10 latency and R3 pin 0 at bit 8
        pins[0] = 1;
        cyc(2);
        rd(2'd0, 32'h0, "R10 not yet at k+1");
        cyc(1);
        rd(2'd0, 32'h100, "R10 set at k+2 R3 bit8");
        wreg(2'd0, 32'h100);
        // R5: falling edge ignored under rising polarity
        pins[0] = 0;
        cyc(5);
        rd(2'd0, 32'h0, "R5 fall ignored");

        // R5 falling polarity on pin 1
        wreg(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, WMASK, "R2 polar mask");
        wreg(2'd2, 32'h200);
        pins[1] = 1; cyc(5);
        rd(2'd0, 32'h0, "R5 rise ignored with fall polarity");
        pins[1] = 0; cyc(5);
        rd(2'd0, 32'h200, "R5 fall detected R3 bit9");

        // R6 NAND unaffected by polarity
        wreg(2'd2, 32'hFFFF_FFFF);
        fifo = 1; cyc(1); fifo = 0; cyc(1);
        rd(2'd0, 32'h201, "R6 nand under polar");
        wreg(2'd2, 32'h0);

        // R9 set beats clear
        fifo = 1; wr = 1; addr = 2'd0; wdata = 32'h1;
        cyc(1);
        fifo = 0; wr = 0; wdata = 0;
        rd(2'd0, 32'h201, "R9 set wins");

        // R3 pins 2 and 3
        wreg(2'd0, 32'hFFFF_FFFF);
        pins[3] = 1; cyc(5);
        rd(2'd0, 32'h800, "R3 pin3 bit11");
        pins[2] = 1; cyc(5);
        rd(2'd0, 32'hC00, "R3 pin2 bit10");

        // R7 masking
        wreg(2'd1, 32'h0);
        cyc(2);
        check("R7 masked irq", {31'd0, irq_out}, 32'h0);
        wreg(2'd1, 32'h400);
        cyc(1);
        check("R7 one enabled", {31'd0, irq_out}, 32'h1);
        pins = '0; cyc(6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule